// File: doc/BRIEF.md
# PS/2 Host Byte Transmitter

This block sends one byte from a host to a PS/2 device over the open-drain clock and data pair. When the user strobes a byte in, the block first holds the clock low with data released. It then pulls data low as the start bit and releases the clock. From that point the device generates the clock. On each falling device clock edge the block presents the next frame bit, and on the last edge it samples the device's acknowledge bit.

Each line is controlled by an output enable, where a high enable pulls the line to 0. A released line is pulled up externally to 1. The block reads both lines back through synchronised inputs. The transfer ends with a one-cycle done pulse and a status code: success, clock timeout or bad acknowledge. At that point both lines are released so that a receive path can take the bus again. All timing limits are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset both line enables are low, busy is low and done is low.
- R2: A start strobe seen while idle makes the block hold the clock enable high with the data enable low for exactly INHIBIT_US microseconds.
- R3: Immediately after that, the data enable also goes high for exactly another INHIBIT_US microseconds. The clock enable is then dropped while the data enable stays high, so the start bit is still held.
- R4: On the first ten falling device clock edges the data line carries, in order, the byte least significant bit first, then an odd parity bit (line level 1 when the byte has an even number of ones), then a stop bit of 1 with data released.
- R5: If the data line is 0 at the eleventh falling edge, the block ends with status 2'b00 (success).
- R6: If the data line is 1 at the eleventh falling edge, the block ends with status 2'b10 (bad acknowledge).
- R7: If no falling edge arrives within FIRST_US microseconds after the clock is released, the block ends with status 2'b01 (timeout).
- R8: Once clocking has begun, if the next falling edge does not arrive within BIT_US microseconds of the previous one, the block ends with status 2'b01. A gap shorter than that limit does not abort the transfer.
- R9: Every ending raises done for exactly one cycle, with both enables low and busy low in that cycle. Status keeps its value until the next ending.
- R10: A start strobe while busy is ignored: the byte on the wire is the one accepted at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txByte | input | 8 | Byte to send, taken on an accepted start strobe |
| txStart | input | 1 | Start strobe, acted on only while idle |
| busy | output | 1 | High from acceptance until the transfer ends |
| done | output | 1 | One-cycle pulse when a transfer ends |
| status | output | 2 | Outcome: 00 success, 01 timeout, 10 bad acknowledge |
| ps2ClkIn | input | 1 | Sensed level of the clock line |
| ps2DatIn | input | 1 | Sensed level of the data line |
| ps2ClkOe | output | 1 | Pulls the clock line low when high |
| ps2DatOe | output | 1 | Pulls the data line low when high |

## Verification
The device model measures both inhibit phases to the exact cycle. A timer that is off by one, or that skips the data-low phase, shows up as a wrong phase length. The model also checks that data is still held low when the clock is released, which catches a start bit that is dropped too early. Bytes with all zeros, all ones and mixed ones are read back bit by bit to catch a wrong bit order or a wrong parity sense. Tests with a silent device and with a device that stops after four edges must end in timeout at the right time, and a design that waits forever or aborts early fails these. A clock period just under the per-edge limit must still succeed, a missing acknowledge must report the bad-acknowledge code, and a start strobe in the middle of a frame must not corrupt the byte on the wire.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INHIBIT,
    ST_START,
    ST_WAIT_FIRST,
    ST_SHIFT
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
  } dpCtrl_t;

  localparam logic [1:0] STAT_OK      = 2'd0;
  localparam logic [1:0] STAT_TIMEOUT = 2'd1;
  localparam logic [1:0] STAT_BADACK  = 2'd2;

  // data bits + parity + stop, each presented on one falling edge
  localparam int FRAME_BITS = 10;

endpackage

// File: rtl/ps2tx_datapath.sv
module ps2tx_datapath
  import ps2tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctl,
  input  logic [7:0] txByte,
  input  logic       ps2ClkIn,
  input  logic       ps2DatIn,
  output logic       fallEdge,
  output logic       datSync,
  output logic       bitQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] clkPipe;
  logic [LAST:0] datPipe;
  logic          clkPrev;
  logic [FRAME_BITS-1:0] shReg;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkPipe <= '1;
          datPipe <= '1;
        end else begin
          clkPipe[0] <= ps2ClkIn;
          datPipe[0] <= ps2DatIn;
        end
      end
    end else begin : gSyncMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkPipe <= '1;
          datPipe <= '1;
        end else begin
          clkPipe <= {clkPipe[LAST-1:0], ps2ClkIn};
          datPipe <= {datPipe[LAST-1:0], ps2DatIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= clkPipe[LAST];
  end

  assign fallEdge = clkPrev & ~clkPipe[LAST];
  assign datSync  = datPipe[LAST];

  // frame shift register: {stop, odd parity, data[7:0]}
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '1;
      bitQ  <= 1'b1;
    end else if (ctl.load) begin
      shReg <= {1'b1, ~^txByte, txByte};
      bitQ  <= 1'b1;
    end else if (ctl.shift) begin
      bitQ  <= shReg[0];
      shReg <= {1'b1, shReg[FRAME_BITS-1:1]};
    end
  end

  AST_PARITY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (^shReg[8:0]) == 1'b1); // R4

endmodule

// File: rtl/ps2tx_ctrl.sv
module ps2tx_ctrl
  import ps2tx_pkg::*;
#(
  parameter int INH_CYC   = 500,
  parameter int FIRST_CYC = 3000,
  parameter int BIT_CYC   = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txStart,
  input  logic       fallEdge,
  input  logic       datSync,
  input  logic       bitQ,
  output dpCtrl_t    ctl,
  output logic       busy,
  output logic       done,
  output logic [1:0] status,
  output logic       clkOe,
  output logic       datOe
);

  localparam int TMAX_A = (INH_CYC > BIT_CYC) ? INH_CYC : BIT_CYC;
  localparam int TMAX   = (FIRST_CYC > TMAX_A) ? FIRST_CYC : TMAX_A;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int EW     = $clog2(FRAME_BITS + 1);

  localparam logic [TW-1:0] INH_LD   = TW'(INH_CYC - 1);
  localparam logic [TW-1:0] FIRST_LD = TW'(FIRST_CYC - 1);
  localparam logic [TW-1:0] BIT_LD   = TW'(BIT_CYC - 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(FRAME_BITS);

  txState_e      state;
  logic [TW-1:0] tmr;
  logic [EW-1:0] edgeCnt;
  logic          tmrZero;

  assign tmrZero   = (tmr == '0);
  assign busy      = (state != ST_IDLE);
  assign clkOe     = (state == ST_INHIBIT) || (state == ST_START);
  assign datOe     = (state == ST_START) || (state == ST_WAIT_FIRST) ||
                     ((state == ST_SHIFT) && !bitQ);
  assign ctl.load  = (state == ST_IDLE) && txStart;
  assign ctl.shift = fallEdge && ((state == ST_WAIT_FIRST) ||
                     ((state == ST_SHIFT) && (edgeCnt != LAST_EDGE)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      edgeCnt <= '0;
      done    <= 1'b0;
      status  <= STAT_OK;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (txStart) begin
            state <= ST_INHIBIT;
            tmr   <= INH_LD;
          end
        end
        ST_INHIBIT: begin
          if (tmrZero) begin
            state <= ST_START;
            tmr   <= INH_LD;
          end else tmr <= tmr - 1'b1;
        end
        ST_START: begin
          if (tmrZero) begin
            state <= ST_WAIT_FIRST;
            tmr   <= FIRST_LD;
          end else tmr <= tmr - 1'b1;
        end
        ST_WAIT_FIRST: begin
          if (fallEdge) begin
            state   <= ST_SHIFT;
            edgeCnt <= EW'(1);
            tmr     <= BIT_LD;
          end else if (tmrZero) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            status <= STAT_TIMEOUT;
          end else tmr <= tmr - 1'b1;
        end
        ST_SHIFT: begin
          if (fallEdge) begin
            if (edgeCnt == LAST_EDGE) begin
              state  <= ST_IDLE;
              done   <= 1'b1;
              status <= datSync ? STAT_BADACK : STAT_OK;
            end else begin
              edgeCnt <= edgeCnt + 1'b1;
              tmr     <= BIT_LD;
            end
          end else if (tmrZero) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            status <= STAT_TIMEOUT;
          end else tmr <= tmr - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!clkOe && !datOe && !busy)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkOe) |-> datOe); // R3
  AST_INHIBIT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(datOe) && clkOe) |-> $past(clkOe)); // R3

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2tx_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int INHIBIT_US  = 500,
  parameter int FIRST_US    = 3000,
  parameter int BIT_US      = 150,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] txByte,
  input  logic       txStart,
  output logic       busy,
  output logic       done,
  output logic [1:0] status,
  input  logic       ps2ClkIn,
  input  logic       ps2DatIn,
  output logic       ps2ClkOe,
  output logic       ps2DatOe
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int INH_CYC    = INHIBIT_US * CYC_PER_US;
  localparam int FIRST_CYC  = FIRST_US * CYC_PER_US;
  localparam int BIT_CYC    = BIT_US * CYC_PER_US;

  dpCtrl_t ctl;
  logic    fallEdge;
  logic    datSync;
  logic    bitQ;

  ps2tx_ctrl #(
    .INH_CYC  (INH_CYC),
    .FIRST_CYC(FIRST_CYC),
    .BIT_CYC  (BIT_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .txStart (txStart),
    .fallEdge(fallEdge),
    .datSync (datSync),
    .bitQ    (bitQ),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done),
    .status  (status),
    .clkOe   (ps2ClkOe),
    .datOe   (ps2DatOe)
  );

  ps2tx_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .txByte  (txByte),
    .ps2ClkIn(ps2ClkIn),
    .ps2DatIn(ps2DatIn),
    .fallEdge(fallEdge),
    .datSync (datSync),
    .bitQ    (bitQ)
  );

endmodule

// File: tb/tb_ps2_host_tx.sv
module tb_ps2_host_tx;

  localparam int CLK_PERIOD = 10;
  localparam int INH   = 100;
  localparam int FIRST = 3000;
  localparam int BITL  = 150;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       txStart = 1'b0;
  logic       busy, done;
  logic [1:0] status;
  logic       ps2ClkOe, ps2DatOe;
  logic       devClkHigh = 1'b1;
  logic       devDatLow = 1'b0;
  wire        clkLine = !ps2ClkOe && devClkHigh;
  wire        datLine = !ps2DatOe && !devDatLow;

  int checks = 0;
  int errs = 0;
  int doneCount = 0;
  int cycles = 0;

  ps2_host_tx #(
    .CLK_HZ(1_000_000), .INHIBIT_US(INH), .FIRST_US(FIRST), .BIT_US(BITL)
  ) dut (
    .clk(clk), .rstN(rstN), .txByte(txByte), .txStart(txStart),
    .busy(busy), .done(done), .status(status),
    .ps2ClkIn(clkLine), .ps2DatIn(datLine),
    .ps2ClkOe(ps2ClkOe), .ps2DatOe(ps2DatOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge done) doneCount++;

  function automatic logic oddPar(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // stopAfter: number of falling edges the device gives (11 = full frame)
  task automatic doXfer(input logic [7:0] b, input bit ackLow, input int stopAfter,
                        input int half, input int firstDelay, input bit poke,
                        input logic [1:0] expStat, input string req);
    int phA = 0;
    int phB = 0;
    int cnt = 0;
    int startDone;
    logic [9:0] rx = '0;
    logic [1:0] st;
    @(negedge clk);
    txByte = b; txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    startDone = doneCount;
    while (ps2ClkOe) begin
      if (!ps2DatOe) phA++; else phB++;
      @(negedge clk);
    end
    chk(phA == INH, "R2", "inhibit cycles", phA, INH);
    chk(phB == INH, "R3", "start-bit cycles", phB, INH);
    chk(ps2DatOe == 1'b1, "R3", "data held at clock release", ps2DatOe, 1);
    if (stopAfter > 0) repeat (firstDelay) @(negedge clk);
    for (int k = 1; k <= 11; k++) begin
      if (k > stopAfter) break;
      if (k == 11 && ackLow) devDatLow = 1'b1;
      devClkHigh = 1'b0;
      repeat (half) @(negedge clk);
      if (k <= 10) rx[k-1] = datLine;
      if (poke && k == 3) begin
        chk(busy == 1'b1, "R10", "busy mid-frame", busy, 1);
        txByte = ~b; txStart = 1'b1;
        @(negedge clk);
        txStart = 1'b0; txByte = b;
      end
      devClkHigh = 1'b1;
      repeat (half) @(negedge clk);
    end
    while (doneCount == startDone && cnt < FIRST + 500) begin
      @(negedge clk);
      cnt++;
    end
    if (stopAfter == 0)
      chk(cnt >= FIRST - 1 && cnt <= FIRST + 1, "R7", "first-clock timeout cycles", cnt, FIRST);
    chk(doneCount == startDone + 1, req, "done seen", doneCount - startDone, 1);
    st = status;
    chk(st == expStat, req, "status", st, expStat);
    chk(!ps2ClkOe && !ps2DatOe && !busy, "R9", "lines released",
        {ps2ClkOe, ps2DatOe, busy}, 0);
    devDatLow = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(status == st, "R9", "status held", status, st);
    if (stopAfter == 11) begin
      chk(rx[7:0] == b, "R4", "data bits", rx[7:0], b);
      chk(rx[8] == oddPar(b), "R4", "parity bit", rx[8], oddPar(b));
      chk(rx[9] == 1'b1, "R4", "stop bit", rx[9], 1);
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    while (cycles < 190_000) begin
      @(posedge clk);
      cycles++;
    end
    errs++;
    $display("FAIL watchdog actual=%0d expected=below", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!ps2ClkOe && !ps2DatOe && !busy && !done, "R1", "reset outputs",
        {ps2ClkOe, ps2DatOe, busy, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ps2ClkOe && !ps2DatOe && !busy && !done, "R1", "idle after reset",
        {ps2ClkOe, ps2DatOe, busy, done}, 0);

    doXfer(8'h00, 1'b1, 11, 40, 20, 1'b0, 2'b00, "R5");
    doXfer(8'hFF, 1'b1, 11, 40, 20, 1'b0, 2'b00, "R5");
    doXfer(8'h01, 1'b1, 11, 35, 50, 1'b0, 2'b00, "R5");
    doXfer(8'hA5, 1'b0, 11, 40, 20, 1'b0, 2'b10, "R6");
    doXfer(8'h3C, 1'b1, 0, 40, 0, 1'b0, 2'b01, "R7");
    doXfer(8'h5A, 1'b1, 4, 40, 20, 1'b0, 2'b01, "R8");
    doXfer(8'hC3, 1'b1, 11, 70, 20, 1'b0, 2'b00, "R8");
    doXfer(8'h96, 1'b1, 11, 40, 20, 1'b1, 2'b00, "R10");

    for (int i = 0; i < 12; i++) begin
      logic [7:0] rb;
      int h, d;
      rb = 8'($urandom);
      h  = $urandom_range(25, 65);
      d  = $urandom_range(5, 2500);
      doXfer(rb, 1'b1, 11, h, d, 1'b0, 2'b00, "R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule